// File: doc/BRIEF.md
# Majority-Vote Branch Direction Predictor

This block guesses whether a conditional branch will be taken by looking at what the same branch did on its most recent executions. It keeps a small table of outcome histories. The table is selected by the low bits of the word address of the branch. Each table slot holds the last `HIST` resolved directions in a shift register. The guess is the majority of those stored bits.

The front end of a pipeline presents the branch address on the lookup port. It gets the direction back in the same cycle, because the read path is purely combinational. When the branch resolves later in the pipeline, the execute stage presents its address and the actual direction on the update port. The slot then shifts that outcome in on the next clock edge.

`HIST` must be odd, so that the vote can never tie. An even value stops elaboration.

Top module: `vote_predictor`

## Requirements
- R1: The slot index is taken from address bits [IDX_W+1:2], where IDX_W = log2(ENTRIES) and ENTRIES defaults to 16. Address bits [1:0] and all bits above the index field have no effect on which slot is used.
- R2: `lk_taken` is a combinational function of the selected slot. It is 1 (taken) when more than HIST/2 of the slot's history bits are 1, and 0 (not taken) otherwise. A stored 1 means taken.
- R3: With the default HIST = 3, the prediction is taken exactly when at least two of the last three recorded outcomes were taken.
- R4: When `up_valid` is 1 at a rising clock edge, the addressed slot shifts left by one. `up_taken` enters at bit 0 and the oldest bit is dropped.
- R5: When `up_valid` is 0, no slot changes, whatever `up_pc` and `up_taken` carry.
- R6: An update changes only the slot its address selects. Every other slot keeps its history.
- R7: When a lookup and an update select the same slot in one cycle, `lk_taken` in that cycle reflects the history before the update.
- R8: A synchronous active-high `rst` clears every history bit, so every lookup after reset predicts not taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | Resolved outcome is present this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual direction, 1 = taken |

## Verification
The bench drives a history back and forth across the two-of-three threshold in both directions. It expects a one-cycle lag, so a design that bypassed the new outcome into a same-cycle lookup would mismatch, and so would a design that shifted from the wrong end. The history pattern 100 must give not taken, and the pattern 101 must give taken. A shifter that kept the wrong bit, or a vote that counted only adjacent bits, gets one of these wrong. Two addresses that share index bits but differ above them must alias to the same slot. An address with nonzero byte-offset bits must not move the index. Cycles with the update strobe low carry live-looking address and outcome values, so a design that ignored the strobe would corrupt a slot that is checked later. A reset in the middle of the run must return every used slot to not taken.

// File: rtl/vp_pkg.sv
package vp_pkg;

    localparam int unsigned MAX_HIST = 32;

    typedef enum logic {
        DIR_NOT_TAKEN = 1'b0,
        DIR_TAKEN     = 1'b1
    } dir_e;

    // Count the set bits among the low n bits and report whether they form a strict majority.
    function automatic dir_e vote(input logic [MAX_HIST-1:0] bits, input int unsigned n);
        int unsigned ones;
        ones = 0;
        for (int unsigned i = 0; i < MAX_HIST; i++) begin
            if (i < n && bits[i]) ones++;
        end
        return (ones > n / 2) ? DIR_TAKEN : DIR_NOT_TAKEN;
    endfunction

endpackage

// File: rtl/vp_index.sv
module vp_index #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 4
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    // Drop the byte offset of a word-aligned address and keep the next IDX_W bits.
    assign idx = pc[IDX_W+1:2];
endmodule

// File: rtl/vp_hist_table.sv
module vp_hist_table #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned HIST    = 3,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [HIST-1:0]  rd_hist,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  vp_pkg::dir_e     wr_dir
);
    logic [HIST-1:0] slot_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        logic hit;
        logic [HIST-1:0] next_hist;
        assign hit = wr_en && (wr_idx == IDX_W'(e));
        if (HIST == 1) begin : g_one
            assign next_hist = wr_dir;
        end else begin : g_many
            assign next_hist = {slot_q[e][HIST-2:0], wr_dir};
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[e] <= '0;
            end else if (hit) begin
                slot_q[e] <= next_hist;
            end
        end
    end

    // Read path sees registered state only, so a same-cycle write is not visible.
    assign rd_hist = slot_q[rd_idx];
endmodule

// File: rtl/vp_vote.sv
module vp_vote #(
    parameter int unsigned HIST = 3
) (
    input  logic [HIST-1:0] hist,
    output vp_pkg::dir_e    dir
);
    logic [vp_pkg::MAX_HIST-1:0] padded;
    assign padded = vp_pkg::MAX_HIST'(hist);
    assign dir    = vp_pkg::vote(padded, HIST);
endmodule

// File: rtl/vote_predictor.sv
module vote_predictor #(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned HIST    = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);
    localparam int unsigned IDX_W = $clog2(ENTRIES);

    if (HIST % 2 == 0 || HIST == 0 || HIST > vp_pkg::MAX_HIST) begin : g_bad_hist
        $error("vote_predictor: HIST must be odd and at most MAX_HIST");
    end

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] up_idx;
    logic [HIST-1:0]  lk_hist;
    vp_pkg::dir_e     lk_dir;
    vp_pkg::dir_e     up_dir;

    assign up_dir = up_taken ? vp_pkg::DIR_TAKEN : vp_pkg::DIR_NOT_TAKEN;

    vp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_index (.pc(lk_pc), .idx(lk_idx));
    vp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_up_index (.pc(up_pc), .idx(up_idx));

    vp_hist_table #(.ENTRIES(ENTRIES), .HIST(HIST)) u_table (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (lk_idx),
        .rd_hist (lk_hist),
        .wr_en   (up_valid),
        .wr_idx  (up_idx),
        .wr_dir  (up_dir)
    );

    vp_vote #(.HIST(HIST)) u_vote (.hist(lk_hist), .dir(lk_dir));

    assign lk_taken = (lk_dir == vp_pkg::DIR_TAKEN);
endmodule

// File: rtl/vp_checker.sv
module vp_checker #(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned HIST    = 3
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] lk_pc,
    input logic            lk_taken,
    input logic            up_valid,
    input logic [PC_W-1:0] up_pc,
    input logic            up_taken
);
    localparam int unsigned IDX_W = $clog2(ENTRIES);

    logic [IDX_W-1:0] c_lk_idx;
    logic [IDX_W-1:0] c_up_idx;
    assign c_lk_idx = lk_pc[IDX_W+1:2];
    assign c_up_idx = up_pc[IDX_W+1:2];

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> !lk_taken) else $error("reset left a taken prediction"); // R8

    AST_OTHER_ENTRY_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(lk_pc) &&
         (!$past(up_valid) || $past(c_up_idx) != c_lk_idx))
        |-> $stable(lk_taken)) else $error("untouched slot changed"); // R6

    if (HIST == 3) begin : g_h3
        AST_TWO_TAKEN: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(rst, 2) &&
             $past(up_valid) && $past(up_valid, 2) &&
             $past(up_taken) && $past(up_taken, 2) &&
             $past(c_up_idx) == $past(c_up_idx, 2) &&
             $past(c_up_idx) == c_lk_idx)
            |-> lk_taken) else $error("two taken did not predict taken"); // R3

        AST_TWO_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(rst, 2) &&
             $past(up_valid) && $past(up_valid, 2) &&
             !$past(up_taken) && !$past(up_taken, 2) &&
             $past(c_up_idx) == $past(c_up_idx, 2) &&
             $past(c_up_idx) == c_lk_idx)
            |-> !lk_taken) else $error("two not taken predicted taken"); // R3
    end
endmodule

bind vote_predictor vp_checker #(.PC_W(PC_W), .ENTRIES(ENTRIES), .HIST(HIST)) u_vp_checker (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
);

// File: tb/tb_vote_predictor.sv
module tb_vote_predictor;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 25;

    typedef struct packed {
        logic        uv;
        logic [31:0] upc;
        logic        ut;
        logic [31:0] lpc;
        logic        exp;
    } vec_t;

    // Slots used: 0x100 -> 0, 0x140 -> 0 (alias), 0x104 -> 1, 0x13C -> 15.
    // Rows with uv=0 carry a live-looking update to 0x104 that must be ignored.
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 32'h104, 1'b1, 32'h100, 1'b0},  // 0  R8 fresh
        '{1'b1, 32'h100, 1'b1, 32'h100, 1'b0},  // 1  R7 pre-update 000
        '{1'b1, 32'h100, 1'b1, 32'h100, 1'b0},  // 2  R7 001
        '{1'b0, 32'h104, 1'b1, 32'h100, 1'b1},  // 3  R3 011
        '{1'b0, 32'h104, 1'b1, 32'h140, 1'b1},  // 4  R1 alias
        '{1'b0, 32'h104, 1'b1, 32'h104, 1'b0},  // 5  R5 R6 slot1 untouched
        '{1'b1, 32'h100, 1'b0, 32'h100, 1'b1},  // 6  R7 011
        '{1'b0, 32'h104, 1'b1, 32'h100, 1'b1},  // 7  R4 110
        '{1'b1, 32'h100, 1'b0, 32'h100, 1'b1},  // 8  R7 110
        '{1'b0, 32'h104, 1'b1, 32'h100, 1'b0},  // 9  R4 100
        '{1'b1, 32'h100, 1'b1, 32'h100, 1'b0},  // 10 R7 100
        '{1'b0, 32'h104, 1'b1, 32'h100, 1'b0},  // 11 R4 001
        '{1'b1, 32'h13C, 1'b1, 32'h100, 1'b0},  // 12 R6 slot0 still 001
        '{1'b1, 32'h13C, 1'b0, 32'h13C, 1'b0},  // 13 R7 001
        '{1'b1, 32'h13C, 1'b1, 32'h13C, 1'b0},  // 14 R2 010
        '{1'b0, 32'h104, 1'b1, 32'h13C, 1'b1},  // 15 R2 101
        '{1'b1, 32'h13C, 1'b0, 32'h13C, 1'b1},  // 16 R7 101
        '{1'b0, 32'h104, 1'b1, 32'h13C, 1'b0},  // 17 R4 010
        '{1'b1, 32'h104, 1'b1, 32'h100, 1'b0},  // 18 R6 slot0 001
        '{1'b1, 32'h104, 1'b1, 32'h104, 1'b0},  // 19 R5 slot1 001
        '{1'b1, 32'h104, 1'b1, 32'h104, 1'b1},  // 20 R3 011
        '{1'b1, 32'h104, 1'b0, 32'h104, 1'b1},  // 21 R3 111
        '{1'b0, 32'h104, 1'b1, 32'h104, 1'b1},  // 22 R4 110
        '{1'b0, 32'h104, 1'b1, 32'h107, 1'b1},  // 23 R1 byte offset
        '{1'b0, 32'h104, 1'b1, 32'hFFFF0104, 1'b1} // 24 R1 high bits
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] lk_pc;
    logic        lk_taken;
    logic        up_valid;
    logic [31:0] up_pc;
    logic        up_taken;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vote_predictor dut (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: lk_taken=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic drive(input logic uv, input logic [31:0] upc, input logic ut,
                         input logic [31:0] lpc);
        @(negedge clk);
        up_valid = uv; up_pc = upc; up_taken = ut; lk_pc = lpc;
        #1;
    endtask

    initial begin
        rst = 1'b1; up_valid = 1'b0; up_pc = '0; up_taken = 1'b0; lk_pc = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i].uv, VEC[i].upc, VEC[i].ut, VEC[i].lpc);
            check($sformatf("R2/vec%0d", i), lk_taken, VEC[i].exp);
        end

        // R8: reset in the middle of the run clears every used slot.
        @(negedge clk);
        rst = 1'b1; up_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 32'h0, 1'b0, 32'h104); check("R8 slot1", lk_taken, 1'b0);
        drive(1'b0, 32'h0, 1'b0, 32'h100); check("R8 slot0", lk_taken, 1'b0);
        drive(1'b0, 32'h0, 1'b0, 32'h13C); check("R8 slot15", lk_taken, 1'b0);

        // R4: alias address writes the shared slot; oldest bit falls off after three.
        drive(1'b1, 32'h140, 1'b1, 32'h100);
        drive(1'b1, 32'h100, 1'b1, 32'h140); check("R4 alias 001", lk_taken, 1'b0);
        drive(1'b1, 32'h100, 1'b0, 32'h100); check("R4 011", lk_taken, 1'b1);
        drive(1'b1, 32'h100, 1'b0, 32'h100); check("R4 110", lk_taken, 1'b1);
        drive(1'b0, 32'h100, 1'b1, 32'h100); check("R4 100", lk_taken, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule